// File: doc/BRIEF.md
# Multichannel Sample Packing Memory Writer

This block sits between an eight-channel converter front end and a 32-bit wide sample SRAM. On every sample strobe it receives one conversion from each channel, together with that channel's out-of-range flag and the running conversion index. It turns each conversion into a 16-bit sample word. Two consecutive conversions of the same channel are joined into one 32-bit memory word.

The first conversion of a pair is parked in a per-channel holding register. When the second conversion arrives, the block writes the eight joined longwords to memory in a burst of one word per cycle. Each channel owns a fixed region of `DEPTH/2` longwords. Channel 0 is at the bottom of memory and the last channel is at the top.

When capture ends and a first conversion is still waiting for its partner, the block writes the waiting sample to memory as a half word. The same happens when a pair is only half present at the start of a run.

Top module: `sample_pack_writer`

## Requirements
- R1: Every sample word has bit 15 equal to 0, bit 14 equal to the channel's out-of-range flag, and bits 13..0 equal to the conversion value.
- R2: A strobe whose conversion index has bit 0 clear is the first of a pair. On its own it causes no memory write; the block keeps the sample.
- R3: A strobe whose index has bit 0 set completes a pair. In the eight cycles after the strobe edge, `mem_we` is high once per channel, channel 0 first, and then low again. The byte enables are 4'b1111 when the earlier half is present.
- R4: In a completed longword, bits 31..16 hold the earlier conversion and bits 15..0 hold the later one.
- R5: The longword address is the channel index × `DEPTH/2` plus the conversion index shifted right by one.
- R6: When `capture` falls while a first conversion is pending, eight writes follow at that pair's address. Each write carries the held word in bits 31..16, zero in bits 15..0, and byte enables 4'b1100.
- R7: A fall of `capture` with nothing pending causes no write.
- R8: A pair-completing strobe with no pending first half writes zero in bits 31..16, the new word in bits 15..0, and byte enables 4'b0011.
- R9: A strobe in the same cycle as a fall of `capture` is taken first. If it is a first half, it is flushed at once as in R6. If it completes a pair, a full write follows and no flush is produced.
- R10: Reset holds `mem_we` low and discards any pending first half. A later fall of `capture` therefore writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| capture | input | 1 | High while acquisition runs; a falling edge ends capture |
| smp_stb | input | 1 | One-cycle strobe: all channel samples valid |
| smp_data | input | NUM_CH*DATA_W | Conversion values, channel c at bits [c*DATA_W +: DATA_W] |
| smp_ovr | input | NUM_CH | Out-of-range flag per channel |
| conv_addr | input | CONV_AW | Index of the current conversion |
| mem_addr | output | ADDR_W | Longword address to the SRAM |
| mem_wdata | output | 32 | Longword write data |
| mem_we | output | 1 | Write enable, one word per cycle |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31..24 |

## Verification
Two functions can fall in the same cycle: a sample strobe and the end of capture. When they coincide, the block must decide in one cycle whether to write a full pair or flush a half word. The bench provokes both forms by dropping `capture` on the very clock edge that carries a strobe. It does this once with a first-half index and once with a pair-completing index. It then judges the result by the eight words that follow and by the absence of any second burst.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int SWORD_W = 16;
    localparam int CONV_MAX_W = 14;

    typedef logic [SWORD_W-1:0] sword_t;

    typedef struct packed {
        sword_t hi;
        sword_t lo;
    } lword_t;

    typedef enum logic [1:0] {
        WR_FULL  = 2'd0,
        WR_UPPER = 2'd1,
        WR_LOWER = 2'd2
    } wr_kind_t;

    function automatic logic [3:0] lanes_of(wr_kind_t k);
        case (k)
            WR_FULL:  return 4'b1111;
            WR_UPPER: return 4'b1100;
            WR_LOWER: return 4'b0011;
            default:  return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/spw_word_fmt.sv
module spw_word_fmt
    import spw_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic [DATA_W-1:0] conv,
    input  logic              ovr,
    output sword_t            word
);
    logic [CONV_MAX_W-1:0] conv_ext;

    assign conv_ext = CONV_MAX_W'(conv);
    assign word     = {1'b0, ovr, conv_ext};

    initial begin
        AST_WIDTH_FITS: assert (DATA_W <= CONV_MAX_W && DATA_W > 0); // R1
    end
endmodule

// File: rtl/spw_pair_hold.sv
module spw_pair_hold
    import spw_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int PAIR_AW = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     first,
    input  logic                     clr,
    input  sword_t [NUM_CH-1:0]      words_in,
    input  logic [PAIR_AW-1:0]       pair_in,
    output logic                     pending,
    output sword_t [NUM_CH-1:0]      words_held,
    output logic [PAIR_AW-1:0]       pair_held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= 1'b0;
            words_held <= '0;
            pair_held  <= '0;
        end else begin
            if (first) begin
                words_held <= words_in;
                pair_held  <= pair_in;
            end
            if (clr)
                pending <= 1'b0;
            else if (first)
                pending <= 1'b1;
        end
    end
endmodule

// File: rtl/spw_write_seq.sv
module spw_write_seq
    import spw_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int PAIR_AW = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  lword_t [NUM_CH-1:0]         bank,
    input  wr_kind_t                    kind,
    input  logic [PAIR_AW-1:0]          pair,
    output logic                        mem_we,
    output logic [$clog2(NUM_CH)+PAIR_AW-1:0] mem_addr,
    output logic [31:0]                 mem_wdata,
    output logic [3:0]                  mem_be
);
    localparam int CH_W = $clog2(NUM_CH);

    logic                  busy;
    logic [CH_W-1:0]       idx;
    lword_t [NUM_CH-1:0]   bank_r;
    wr_kind_t              kind_r;
    logic [PAIR_AW-1:0]    pair_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            bank_r <= '0;
            kind_r <= WR_FULL;
            pair_r <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            idx    <= '0;
            bank_r <= bank;
            kind_r <= kind;
            pair_r <= pair;
        end else if (busy) begin
            if (idx == CH_W'(NUM_CH - 1))
                busy <= 1'b0;
            idx <= idx + 1'b1;
        end
    end

    assign mem_we    = busy;
    assign mem_addr  = {idx, pair_r};
    assign mem_wdata = busy ? bank_r[idx] : 32'd0;
    assign mem_be    = busy ? lanes_of(kind_r) : 4'b0000;

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy); // R3
endmodule

// File: rtl/sample_pack_writer.sv
module sample_pack_writer
    import spw_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 14,
    parameter int DEPTH  = 131072,
    localparam int CONV_AW = $clog2(DEPTH),
    localparam int ADDR_W  = $clog2(NUM_CH) + CONV_AW - 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     capture,
    input  logic                     smp_stb,
    input  logic [NUM_CH*DATA_W-1:0] smp_data,
    input  logic [NUM_CH-1:0]        smp_ovr,
    input  logic [CONV_AW-1:0]       conv_addr,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [31:0]              mem_wdata,
    output logic                     mem_we,
    output logic [3:0]               mem_be
);
    localparam int PAIR_AW = CONV_AW - 1;
    localparam int REGION  = DEPTH / 2;

    sword_t [NUM_CH-1:0]  cur_words;
    sword_t [NUM_CH-1:0]  held_words;
    logic [PAIR_AW-1:0]   cur_pair;
    logic [PAIR_AW-1:0]   held_pair;
    logic                 pending;
    logic                 capture_q;
    logic                 stop_evt;
    logic                 first_stb;
    logic                 second_stb;
    logic                 flush;
    logic                 load;
    lword_t [NUM_CH-1:0]  bank;
    wr_kind_t             kind;
    logic [PAIR_AW-1:0]   load_pair;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_fmt
            spw_word_fmt #(.DATA_W(DATA_W)) u_fmt (
                .conv (smp_data[c*DATA_W +: DATA_W]),
                .ovr  (smp_ovr[c]),
                .word (cur_words[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) capture_q <= 1'b0;
        else     capture_q <= capture;
    end

    assign cur_pair   = conv_addr[CONV_AW-1:1];
    assign stop_evt   = capture_q & ~capture;
    assign first_stb  = smp_stb & ~conv_addr[0];
    assign second_stb = smp_stb &  conv_addr[0];
    assign flush      = stop_evt & ~second_stb & (first_stb | pending);
    assign load       = second_stb | flush;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (flush) begin
                bank[c].hi = first_stb ? cur_words[c] : held_words[c];
                bank[c].lo = '0;
            end else begin
                bank[c].hi = pending ? held_words[c] : '0;
                bank[c].lo = cur_words[c];
            end
        end
        if (flush)        kind = WR_UPPER;
        else if (pending) kind = WR_FULL;
        else              kind = WR_LOWER;
        load_pair = (flush && !first_stb) ? held_pair : cur_pair;
    end

    spw_pair_hold #(.NUM_CH(NUM_CH), .PAIR_AW(PAIR_AW)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .first      (first_stb),
        .clr        (load),
        .words_in   (cur_words),
        .pair_in    (cur_pair),
        .pending    (pending),
        .words_held (held_words),
        .pair_held  (held_pair)
    );

    spw_write_seq #(.NUM_CH(NUM_CH), .PAIR_AW(PAIR_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .bank      (bank),
        .kind      (kind),
        .pair      (load_pair),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be)
    );

    AST_FMT_TOP_BITS: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata[31] == 1'b0 && mem_wdata[15] == 1'b0)); // R1
    AST_REGION_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(REGION))); // R5
    AST_HALF_LOWER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_be == 4'b1100) |-> (mem_wdata[15:0] == 16'd0)); // R6
    AST_LOWER_ONLY_ZERO_HI: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_be == 4'b0011) |-> (mem_wdata[31:16] == 16'd0)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !mem_we); // R10
endmodule

// File: tb/sample_pack_writer_tb.sv
`timescale 1ns/1ps
module sample_pack_writer_tb;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 14;
    localparam int DEPTH  = 16;
    localparam int CONV_AW = 4;
    localparam int ADDR_W  = 6;
    localparam int REGION  = DEPTH / 2;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     capture = 1'b0;
    logic                     smp_stb = 1'b0;
    logic [NUM_CH*DATA_W-1:0] smp_data = '0;
    logic [NUM_CH-1:0]        smp_ovr = '0;
    logic [CONV_AW-1:0]       conv_addr = '0;
    logic [ADDR_W-1:0]        mem_addr;
    logic [31:0]              mem_wdata;
    logic                     mem_we;
    logic [3:0]               mem_be;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sample_pack_writer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .capture(capture), .smp_stb(smp_stb),
        .smp_data(smp_data), .smp_ovr(smp_ovr), .conv_addr(conv_addr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_be(mem_be)
    );

    function automatic logic [15:0] sw(int ch, int n);
        int d;
        logic o;
        d = (ch * 1237 + n * 811 + 5) % 16384;
        o = ((ch + n) % 3) == 0;
        return {1'b0, o, 14'(d)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input int n, input bit cap);
        @(negedge clk);
        conv_addr = CONV_AW'(n);
        for (int c = 0; c < NUM_CH; c++) begin
            logic [15:0] w;
            w = sw(c, n);
            smp_data[c*DATA_W +: DATA_W] = w[13:0];
            smp_ovr[c] = w[14];
        end
        smp_stb = 1'b1;
        capture = cap;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic idle(input int cyc, input string req);
        for (int k = 0; k < cyc; k++) begin
            chk(mem_we == 1'b0, req, 64'(mem_we), 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic burst(input int pair, input int up_n, input bit up_v,
                         input int lo_n, input bit lo_v, input string req);
        for (int c = 0; c < NUM_CH; c++) begin
            logic [15:0] hi;
            logic [15:0] lo;
            logic [42:0] act;
            logic [42:0] exp;
            hi  = up_v ? sw(c, up_n) : 16'd0;
            lo  = lo_v ? sw(c, lo_n) : 16'd0;
            act = {mem_we, mem_be, mem_addr, mem_wdata};
            exp = {1'b1, up_v, up_v, lo_v, lo_v, ADDR_W'(c * REGION + pair), hi, lo};
            chk(act == exp, req, 64'(act), 64'(exp));
            @(negedge clk);
        end
        chk(mem_we == 1'b0, req, 64'(mem_we), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0 && mem_be == 4'd0, "R10 reset state", 64'({mem_we, mem_be}), 64'd0);
        rst = 1'b0;
        capture = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5: sweep of every conversion index
        for (int n = 0; n < DEPTH; n++) begin
            pulse(n, 1'b1);
            if ((n % 2) == 0) idle(3, "R2 first half no write");
            else burst(n / 2, n - 1, 1'b1, n, 1'b1, "R1/R3/R4/R5 pair write");
        end

        // R7: stop with nothing pending
        @(negedge clk); capture = 1'b0;
        @(negedge clk);
        idle(12, "R7 stop without pending");

        // R6: stop while a first half waits
        capture = 1'b1;
        pulse(4, 1'b1);
        idle(2, "R2 hold before stop");
        capture = 1'b0;
        @(negedge clk);
        burst(2, 4, 1'b1, 0, 1'b0, "R6 flush half word");

        // R8: completing strobe with no first half
        capture = 1'b1;
        @(negedge clk);
        pulse(7, 1'b1);
        burst(3, 0, 1'b0, 7, 1'b1, "R8 lower only");

        // R9: first half coincident with stop
        pulse(10, 1'b0);
        burst(5, 10, 1'b1, 0, 1'b0, "R9 first half flushed at stop");
        idle(4, "R9 single flush");

        // R9: pair completion coincident with stop
        capture = 1'b1;
        @(negedge clk);
        pulse(12, 1'b1);
        idle(2, "R2 hold");
        pulse(13, 1'b0);
        burst(6, 12, 1'b1, 13, 1'b1, "R9 pair wins over stop");
        idle(10, "R9 no flush after pair");

        // R10: reset drops a pending half
        capture = 1'b1;
        @(negedge clk);
        pulse(2, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk(mem_we == 1'b0, "R10 quiet in reset", 64'(mem_we), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        capture = 1'b0;
        @(negedge clk);
        idle(12, "R10 pending cleared by reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule